// File: doc/BRIEF.md
# Completion Packet Header Decoder and Payload Checker

This block sits on the receive side of a PCIe requester. Completion packets arrive as a stream of 32-bit doublewords, one per accepted beat. A start marker flags the first doubleword of each packet and an end marker flags the last one. The block reads the three-doubleword completion header. It then presents every decoded field for one cycle with a header strobe. After that it forwards the payload words one at a time, each carrying the tag of its completion, so the requester can match returned data to the read that asked for it.

The length field promises a number of payload words, and the block checks the packet against it. If the promised data is missing, cut short, or followed by extra words, a length-error pulse is raised. Such a read is never mistaken for a good one. A completion with a non-successful status raises a status-error pulse alongside the header strobe. Packets whose type byte is not a completion are discarded with a format-error pulse. All outputs are registered and appear one cycle after the beat that caused them. The input is always ready once reset is over.

Control is held in a six-state machine:
- `ST_IDLE` waits for a start beat.
- `ST_HDR1` and `ST_HDR2` take the second and third header words.
- `ST_DATA` forwards payload.
- `ST_EXCESS` waits for a beat beyond the promised length.
- `ST_DRAIN` discards beats until an end marker arrives.

The transitions are:
- IDLE→HDR1 on a completion start beat.
- IDLE→DRAIN on a foreign start beat.
- HDR1→HDR2 on the next beat.
- HDR2→DATA for a with-data completion.
- HDR2→DRAIN for a data-less completion that does not end.
- DATA→EXCESS when the last promised word carries no end marker.
- EXCESS→DRAIN on an excess beat that does not end.
- Any state→IDLE on an end beat.

Top module: `cpl_rx_parser`

## Requirements
- R1: While rst_n is low, in_ready, hdr_valid, dat_valid, dat_last, err_len, err_status and err_fmt are all 0; in_ready is 1 from the first clock edge after reset is released.
- R2: For a start beat whose bits 31:24 are 0x4A (completion with data), the header fields are decoded as follows, and hdr_valid pulses for one cycle after the third header beat with hdr_has_data = 1:
  - length from beat 0 bits 9:0
  - completer ID from beat 1 bits 31:16
  - status from beat 1 bits 15:13
  - byte count from beat 1 bits 11:0
  - requester ID from beat 2 bits 31:16
  - tag from beat 2 bits 15:8
  - lower address from beat 2 bits 6:0
- R3: Payload words are delivered in arrival order on dat_data with dat_tag equal to the header tag. dat_last is set only on the word whose index equals the length. A length field of 0 means 1024 words.
- R4: A completion without data (bits 31:24 = 0x0A) produces hdr_valid with hdr_has_data = 0 and no data word. If its third beat carries the end marker, no error is raised.
- R5: A with-data completion whose third header beat carries the end marker raises err_len together with hdr_valid and delivers no data word.
- R6: If the end marker arrives on a payload word before the promised count, that word is still delivered with dat_last = 0, and err_len pulses with it.
- R7: Payload beats beyond the promised count are not delivered. err_len pulses once, on the first excess beat. Further beats up to the end marker are discarded silently.
- R8: A nonzero completion status raises err_status together with hdr_valid, with the code on hdr_status and the tag on hdr_tag. The codes are 1 (unsupported request) and 4 (completer abort). Status 0 (successful) raises no err_status.
- R9: A start beat with any other type byte pulses err_fmt. No hdr_valid and no data word are produced for that packet, and the packet is dropped up to its end marker.
- R10: Beats without a start marker that arrive while no packet is open produce no output at all.
- R11: A completion without data that does not end on its third beat raises err_len together with hdr_valid. Its remaining beats are discarded up to the end marker.
- R12: An end marker on header beat 0 or header beat 1 raises err_len and produces no hdr_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat is valid |
| in_ready | output | 1 | Block accepts a beat |
| in_data | input | 32 | Input doubleword |
| in_sop | input | 1 | First doubleword of a packet |
| in_eop | input | 1 | Last doubleword of a packet |
| hdr_valid | output | 1 | One-cycle strobe: decoded header fields valid |
| hdr_has_data | output | 1 | Completion carries payload |
| hdr_length | output | 10 | Promised payload doublewords (0 = 1024) |
| hdr_completer_id | output | 16 | Completer ID |
| hdr_status | output | 3 | Completion status code |
| hdr_byte_count | output | 12 | Remaining byte count |
| hdr_requester_id | output | 16 | Requester ID |
| hdr_tag | output | 8 | Transaction tag |
| hdr_lower_addr | output | 7 | Lower address of the first returned byte |
| dat_valid | output | 1 | Payload word valid |
| dat_data | output | 32 | Payload word |
| dat_tag | output | 8 | Tag of the completion the word belongs to |
| dat_last | output | 1 | Word completes the promised length |
| err_len | output | 1 | Length error pulse |
| err_status | output | 1 | Non-successful status pulse |
| err_fmt | output | 1 | Unknown packet type pulse |

## Verification
The embedded assertions check several relations on every cycle:
- A data-less header is never followed by a data word.
- dat_last appears only with dat_valid.
- A status error appears only with the header strobe.
- Header, data and format strobes never overlap.
- The tag is steady across a run of data words.
- The word counter never decrements past zero.

The decoded field values are shown only by the directed scenarios. So are the exact beat on which err_len fires for missing, short, excess and truncated packets, the handling of 1024-word completions, and the silent discarding of stray or excess beats.

// File: rtl/cpl_rx_pkg.sv
package cpl_rx_pkg;

    localparam logic [7:0] FT_CPL_DATA   = 8'h4A;
    localparam logic [7:0] FT_CPL_NODATA = 8'h0A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR1,
        ST_HDR2,
        ST_DATA,
        ST_EXCESS,
        ST_DRAIN
    } cpl_state_e;

    function automatic logic is_cpl_type(input logic [7:0] ft);
        return (ft == FT_CPL_DATA) || (ft == FT_CPL_NODATA);
    endfunction

endpackage

// File: rtl/cpl_rx_hdr_capture.sv
module cpl_rx_hdr_capture #(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_dw0,
    input  logic             cap_dw1,
    input  logic             cap_dw2,
    input  logic [31:0]      data,
    output logic             has_data,
    output logic [LEN_W-1:0] length,
    output logic [15:0]      completer_id,
    output logic [2:0]       status,
    output logic [11:0]      byte_count,
    output logic [15:0]      requester_id,
    output logic [7:0]       tag,
    output logic [6:0]       lower_addr
);
    import cpl_rx_pkg::*;

    // Header word 0: type byte and length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            has_data <= 1'b0;
            length   <= '0;
        end else if (cap_dw0) begin
            has_data <= (data[31:24] == FT_CPL_DATA);
            length   <= data[LEN_W-1:0];
        end
    end

    // Header word 1: completer, status, byte count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            completer_id <= '0;
            status       <= '0;
            byte_count   <= '0;
        end else if (cap_dw1) begin
            completer_id <= data[31:16];
            status       <= data[15:13];
            byte_count   <= data[11:0];
        end
    end

    // Header word 2: requester, tag, lower address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            requester_id <= '0;
            tag          <= '0;
            lower_addr   <= '0;
        end else if (cap_dw2) begin
            requester_id <= data[31:16];
            tag          <= data[15:8];
            lower_addr   <= data[6:0];
        end
    end

endmodule

// File: rtl/cpl_rx_len_cnt.sv
module cpl_rx_len_cnt #(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             dec,
    output logic             rem_one
);
    localparam int CNT_W = LEN_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1) << LEN_W;

    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= (load_len == '0) ? FULL_CNT : {1'b0, load_len};
        end else if (dec) begin
            remaining <= remaining - CNT_W'(1);
        end
    end

    assign rem_one = (remaining == CNT_W'(1));

    // R3
    cnt_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (remaining != '0));

endmodule

// File: rtl/cpl_rx_fsm.sv
module cpl_rx_fsm (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic [31:0] in_data,
    input  logic        has_data,
    input  logic        status_nz,
    input  logic        rem_one,
    output logic        in_ready,
    output logic        cap_dw0,
    output logic        cap_dw1,
    output logic        cap_dw2,
    output logic        cnt_dec,
    output logic        hdr_valid,
    output logic        dat_valid,
    output logic [31:0] dat_data,
    output logic        dat_last,
    output logic        err_len,
    output logic        err_status,
    output logic        err_fmt
);
    import cpl_rx_pkg::*;

    cpl_state_e state, state_nx;
    logic       beat;
    logic       type_ok;

    assign beat    = in_valid && in_ready;
    assign type_ok = is_cpl_type(in_data[31:24]);

    assign cap_dw0 = beat && (state == ST_IDLE) && in_sop;
    assign cap_dw1 = beat && (state == ST_HDR1);
    assign cap_dw2 = beat && (state == ST_HDR2);
    assign cnt_dec = beat && (state == ST_DATA);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        if (beat) begin
            unique case (state)
                ST_IDLE: begin
                    if (in_sop) begin
                        if (in_eop)       state_nx = ST_IDLE;
                        else if (type_ok) state_nx = ST_HDR1;
                        else              state_nx = ST_DRAIN;
                    end
                end
                ST_HDR1: state_nx = in_eop ? ST_IDLE : ST_HDR2;
                ST_HDR2: begin
                    if (in_eop)        state_nx = ST_IDLE;
                    else if (has_data) state_nx = ST_DATA;
                    else               state_nx = ST_DRAIN;
                end
                ST_DATA: begin
                    if (in_eop)       state_nx = ST_IDLE;
                    else if (rem_one) state_nx = ST_EXCESS;
                end
                ST_EXCESS: state_nx = in_eop ? ST_IDLE : ST_DRAIN;
                ST_DRAIN:  if (in_eop) state_nx = ST_IDLE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_ready   <= 1'b0;
            hdr_valid  <= 1'b0;
            dat_valid  <= 1'b0;
            dat_data   <= '0;
            dat_last   <= 1'b0;
            err_len    <= 1'b0;
            err_status <= 1'b0;
            err_fmt    <= 1'b0;
        end else begin
            in_ready   <= 1'b1;
            hdr_valid  <= 1'b0;
            dat_valid  <= 1'b0;
            dat_last   <= 1'b0;
            err_len    <= 1'b0;
            err_status <= 1'b0;
            err_fmt    <= 1'b0;
            if (beat) begin
                unique case (state)
                    ST_IDLE: begin
                        if (in_sop) begin
                            if (!type_ok)    err_fmt <= 1'b1;
                            else if (in_eop) err_len <= 1'b1;
                        end
                    end
                    ST_HDR1: begin
                        if (in_eop) err_len <= 1'b1;
                    end
                    ST_HDR2: begin
                        hdr_valid  <= 1'b1;
                        err_status <= status_nz;
                        // missing payload, or a data-less packet that runs on
                        err_len    <= has_data ? in_eop : !in_eop;
                    end
                    ST_DATA: begin
                        dat_valid <= 1'b1;
                        dat_data  <= in_data;
                        dat_last  <= rem_one;
                        err_len   <= in_eop && !rem_one;
                    end
                    ST_EXCESS: err_len <= 1'b1;
                    ST_DRAIN: ;
                    default: ;
                endcase
            end
        end
    end

    // R4
    nodata_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !has_data) |=> !dat_valid);

    // R3
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_last |-> dat_valid);

    // R8
    status_with_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_status |-> hdr_valid);

    // R9
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hdr_valid, dat_valid, err_fmt}));

    // R1
    ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_ready);

endmodule

// File: rtl/cpl_rx_parser.sv
module cpl_rx_parser #(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_data,
    input  logic             in_sop,
    input  logic             in_eop,
    output logic             hdr_valid,
    output logic             hdr_has_data,
    output logic [LEN_W-1:0] hdr_length,
    output logic [15:0]      hdr_completer_id,
    output logic [2:0]       hdr_status,
    output logic [11:0]      hdr_byte_count,
    output logic [15:0]      hdr_requester_id,
    output logic [7:0]       hdr_tag,
    output logic [6:0]       hdr_lower_addr,
    output logic             dat_valid,
    output logic [31:0]      dat_data,
    output logic [7:0]       dat_tag,
    output logic             dat_last,
    output logic             err_len,
    output logic             err_status,
    output logic             err_fmt
);
    logic cap_dw0, cap_dw1, cap_dw2, cnt_dec, rem_one;

    cpl_rx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .in_data    (in_data),
        .has_data   (hdr_has_data),
        .status_nz  (hdr_status != 3'd0),
        .rem_one    (rem_one),
        .in_ready   (in_ready),
        .cap_dw0    (cap_dw0),
        .cap_dw1    (cap_dw1),
        .cap_dw2    (cap_dw2),
        .cnt_dec    (cnt_dec),
        .hdr_valid  (hdr_valid),
        .dat_valid  (dat_valid),
        .dat_data   (dat_data),
        .dat_last   (dat_last),
        .err_len    (err_len),
        .err_status (err_status),
        .err_fmt    (err_fmt)
    );

    cpl_rx_hdr_capture #(.LEN_W(LEN_W)) u_hdr (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_dw0      (cap_dw0),
        .cap_dw1      (cap_dw1),
        .cap_dw2      (cap_dw2),
        .data         (in_data),
        .has_data     (hdr_has_data),
        .length       (hdr_length),
        .completer_id (hdr_completer_id),
        .status       (hdr_status),
        .byte_count   (hdr_byte_count),
        .requester_id (hdr_requester_id),
        .tag          (hdr_tag),
        .lower_addr   (hdr_lower_addr)
    );

    cpl_rx_len_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cap_dw0),
        .load_len (in_data[LEN_W-1:0]),
        .dec      (cnt_dec),
        .rem_one  (rem_one)
    );

    assign dat_tag = hdr_tag;

    // R3
    tag_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && $past(dat_valid)) |-> $stable(dat_tag));

endmodule

// File: tb/cpl_rx_parser_bench.sv
module cpl_rx_parser_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        hdr_valid, hdr_has_data;
    logic [9:0]  hdr_length;
    logic [15:0] hdr_completer_id, hdr_requester_id;
    logic [2:0]  hdr_status;
    logic [11:0] hdr_byte_count;
    logic [7:0]  hdr_tag, dat_tag;
    logic [6:0]  hdr_lower_addr;
    logic        dat_valid, dat_last, err_len, err_status, err_fmt;
    logic [31:0] dat_data;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpl_rx_parser u_cpl_rx_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .hdr_valid(hdr_valid), .hdr_has_data(hdr_has_data), .hdr_length(hdr_length),
        .hdr_completer_id(hdr_completer_id), .hdr_status(hdr_status),
        .hdr_byte_count(hdr_byte_count), .hdr_requester_id(hdr_requester_id),
        .hdr_tag(hdr_tag), .hdr_lower_addr(hdr_lower_addr),
        .dat_valid(dat_valid), .dat_data(dat_data), .dat_tag(dat_tag),
        .dat_last(dat_last), .err_len(err_len), .err_status(err_status),
        .err_fmt(err_fmt)
    );

    // snapshot of outputs one cycle after a beat
    logic        s_hv, s_dv, s_dl, s_el, s_es, s_ef;
    logic [31:0] s_dd;
    logic [7:0]  s_dt;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic send(input logic [31:0] d, input logic sop, input logic eop);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sop = sop; in_eop = eop;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        s_hv = hdr_valid; s_dv = dat_valid; s_dl = dat_last;
        s_el = err_len; s_es = err_status; s_ef = err_fmt;
        s_dd = dat_data; s_dt = dat_tag;
    endtask

    function automatic logic [31:0] mk_dw1(input logic [15:0] cid, input logic [2:0] st,
                                           input logic [11:0] bc);
        return {cid, st, 1'b0, bc};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        // R1
        chk("R1", "ready in reset", in_ready, 0);
        chk("R1", "strobes in reset", {hdr_valid, dat_valid, dat_last, err_len, err_status, err_fmt}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", in_ready, 1);
    endtask

    task automatic t_cpld_single();
        send(32'h4A000001, 1, 0);
        send(32'h09000004, 0, 0);
        send(32'h00002004, 0, 0);
        // R2
        chk("R2", "hdr_valid", s_hv, 1);
        chk("R2", "has_data", hdr_has_data, 1);
        chk("R2", "length", hdr_length, 1);
        chk("R2", "completer", hdr_completer_id, 16'h0900);
        chk("R2", "status", hdr_status, 0);
        chk("R2", "byte count", hdr_byte_count, 4);
        chk("R2", "requester", hdr_requester_id, 0);
        chk("R2", "tag", hdr_tag, 8'h20);
        chk("R2", "lower addr", hdr_lower_addr, 7'h04);
        chk("R8", "no status err on success", s_es, 0);
        send(32'hCAFEF00D, 0, 1);
        chk("R3", "data word", s_dd, 32'hCAFEF00D);
        chk("R3", "valid/last/tag", {s_dv, s_dl, s_dt}, {1'b1, 1'b1, 8'h20});
        chk("R3", "no length err", s_el, 0);
    endtask

    task automatic t_cpld_multi();
        logic ok;
        ok = 1'b1;
        send(32'h4A000004, 1, 0);
        send(mk_dw1(16'h0100, 0, 12'd16), 0, 0);
        send(32'h00AB1F00, 0, 0);
        chk("R2", "requester multi", hdr_requester_id, 16'h00AB);
        for (int i = 0; i < 4; i++) begin
            send(32'h1000_0000 + i, 0, i == 3);
            if (!(s_dv && s_dd == 32'h1000_0000 + i && s_dt == 8'h1F && s_dl == (i == 3) && !s_el))
                ok = 1'b0;
        end
        // R3
        chk("R3", "four words in order, last on fourth", ok, 1);
    endtask

    task automatic t_len_zero();
        int nlast;
        int nbad;
        nlast = 0;
        nbad = 0;
        send(32'h4A000000, 1, 0);
        send(mk_dw1(16'h0200, 0, 12'd0), 0, 0);
        send(32'h00005500, 0, 0);
        for (int i = 0; i < 1024; i++) begin
            send(i, 0, i == 1023);
            if (!s_dv || s_dd != i || s_el) nbad++;
            if (s_dl) nlast = i + 1;
        end
        // R3
        chk("R3", "1024-word payload words", nbad, 0);
        chk("R3", "1024-word last index", nlast, 1024);
    endtask

    task automatic t_cpl_nodata();
        send(32'h0A000000, 1, 0);
        send(mk_dw1(16'h0300, 0, 12'd0), 0, 0);
        send(32'h00007700, 0, 1);
        // R4
        chk("R4", "hdr strobe, no data flag", {s_hv, hdr_has_data}, 2'b10);
        chk("R4", "no len error", s_el, 0);
        @(negedge clk);
        chk("R4", "no data word", dat_valid, 0);
    endtask

    task automatic t_missing();
        send(32'h4A000001, 1, 0);
        send(32'h09000004, 0, 0);
        send(32'h00002104, 0, 1);
        // R5
        chk("R5", "hdr+len err on missing payload", {s_hv, s_el, s_dv}, 3'b110);
        @(negedge clk);
        chk("R5", "no data afterwards", dat_valid, 0);
    endtask

    task automatic t_short();
        send(32'h4A000003, 1, 0);
        send(mk_dw1(16'h0400, 0, 12'd12), 0, 0);
        send(32'h00003000, 0, 0);
        send(32'hAAAA0001, 0, 0);
        chk("R6", "first word no err", {s_dv, s_el}, 2'b10);
        send(32'hAAAA0002, 0, 1);
        // R6
        chk("R6", "short end: valid,last,err", {s_dv, s_dl, s_el}, 3'b101);
        chk("R6", "short end data", s_dd, 32'hAAAA0002);
    endtask

    task automatic t_excess();
        send(32'h4A000002, 1, 0);
        send(mk_dw1(16'h0500, 0, 12'd8), 0, 0);
        send(32'h00004100, 0, 0);
        send(32'hBBBB0001, 0, 0);
        send(32'hBBBB0002, 0, 0);
        chk("R7", "last promised word", {s_dv, s_dl, s_el}, 3'b110);
        send(32'hBBBB0003, 0, 0);
        // R7
        chk("R7", "first excess beat", {s_dv, s_el}, 2'b01);
        send(32'hBBBB0004, 0, 1);
        chk("R7", "later excess silent", {s_dv, s_el, s_hv}, 3'b000);
    endtask

    task automatic t_status();
        send(32'h0A000000, 1, 0);
        send(mk_dw1(16'h0600, 3'd1, 12'd0), 0, 0);
        send(32'h00003300, 0, 1);
        // R8
        chk("R8", "UR strobes", {s_hv, s_es}, 2'b11);
        chk("R8", "UR code and tag", {hdr_status, hdr_tag}, {3'd1, 8'h33});
        send(32'h0A000000, 1, 0);
        send(mk_dw1(16'h0600, 3'd4, 12'd0), 0, 0);
        send(32'h00004400, 0, 1);
        chk("R8", "CA strobes", {s_hv, s_es}, 2'b11);
        chk("R8", "CA code and tag", {hdr_status, hdr_tag}, {3'd4, 8'h44});
    endtask

    task automatic t_badfmt();
        logic any;
        any = 1'b0;
        send(32'h40000001, 1, 0);
        // R9
        chk("R9", "fmt error", {s_ef, s_hv}, 2'b10);
        send(32'h00001F0F, 0, 0); any |= s_hv | s_dv;
        send(32'h40000100, 0, 0); any |= s_hv | s_dv;
        send(32'h123ABCDE, 0, 1); any |= s_hv | s_dv;
        chk("R9", "packet dropped", any, 0);
    endtask

    task automatic t_stray();
        logic any;
        any = 1'b0;
        send(32'h4A000001, 0, 0); any |= s_hv | s_dv | s_el | s_es | s_ef;
        send(32'h09000004, 0, 0); any |= s_hv | s_dv | s_el | s_es | s_ef;
        send(32'h00002004, 0, 1); any |= s_hv | s_dv | s_el | s_es | s_ef;
        // R10
        chk("R10", "stray beats silent", any, 0);
        send(32'h0A000000, 1, 0);
        send(mk_dw1(16'h0700, 0, 12'd0), 0, 0);
        send(32'h00006600, 0, 1);
        chk("R10", "next packet decodes", {s_hv, hdr_tag}, {1'b1, 8'h66});
    endtask

    task automatic t_nodata_long();
        send(32'h0A000000, 1, 0);
        send(mk_dw1(16'h0800, 0, 12'd0), 0, 0);
        send(32'h00007800, 0, 0);
        // R11
        chk("R11", "hdr with len err", {s_hv, s_el}, 2'b11);
        send(32'hDEADBEEF, 0, 1);
        chk("R11", "extra beat dropped", {s_dv, s_el, s_hv}, 3'b000);
    endtask

    task automatic t_trunc();
        send(32'h4A000001, 1, 1);
        // R12
        chk("R12", "eop on beat 0", {s_el, s_hv}, 2'b10);
        send(32'h4A000001, 1, 0);
        chk("R12", "beat 0 quiet", s_el, 0);
        send(32'h09000004, 0, 1);
        chk("R12", "eop on beat 1", {s_el, s_hv}, 2'b10);
        @(negedge clk);
        chk("R12", "no header strobe after", hdr_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_cpld_single();
        t_cpld_multi();
        t_len_zero();
        t_cpl_nodata();
        t_missing();
        t_short();
        t_excess();
        t_status();
        t_badfmt();
        t_stray();
        t_nodata_long();
        t_trunc();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule